// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store that sits next to a direct-mapped cache and keeps the lines that cache throws out. Whenever the main cache replaces a line, it pushes the tag, data and dirty flag of the outgoing line in through the insert port. When the main cache misses, it presents the wanted block address on the lookup port before it goes to the next memory level. On a hit the buffer hands the line back, together with its dirty flag, and drops its own copy. The main cache can then swap the line back in without any next-level traffic.

Lookups compare the full block address against every entry at once. When all entries are occupied, the entry that was inserted first is the one replaced. If that entry is clean, it is simply overwritten. If it is dirty, the buffer holds the insert and offers the line on a ready/valid writeback port. The insert completes once the next level has taken that line. An entry freed by a lookup hit in the same cycle as an insert is reused at once for the incoming line.

Top module: `victim_buf`

## Requirements
- R1: After reset every lookup misses, ins_ready is 1, wb_valid is 0 and rsp_valid is 0.
- R2: A lookup of a tag held in the buffer gives rsp_valid=1 and rsp_hit=1 on the cycle after the request, with rsp_data and rsp_dirty equal to the values inserted with that tag.
- R3: A lookup of a tag not held in the buffer gives rsp_valid=1 and rsp_hit=0 on the cycle after the request.
- R4: A lookup hit removes the entry, so a later lookup of the same tag misses unless the tag was inserted again.
- R5: The lookup compares all TAG_W bits. A tag that differs from a stored one only in bit 31 or only in bit 0 misses.
- R6: An insert into a full buffer replaces the entry inserted earliest, and the other entries are kept.
- R7: While any entry is empty, an insert fills an empty entry and removes no stored line.
- R8: An insert into a full buffer whose earliest entry is dirty drives ins_ready=0 and wb_valid=1, with wb_tag and wb_data holding that entry. This lasts until wb_ready=1. After that handshake the line is gone and the next insert is accepted.
- R9: An insert into a full buffer whose earliest entry is clean is accepted at once with wb_valid=0, and the clean line is dropped.
- R10: When an insert and a lookup hit arrive in the same cycle on a full buffer, the insert is accepted without any writeback, and every other stored line is kept.
- R11: rsp_valid is 1 exactly on the cycles that follow a cycle with lk_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Evicted line offered by the main cache |
| ins_ready | output | 1 | Insert is accepted this cycle |
| ins_tag | input | TAG_W | Block address of the evicted line |
| ins_data | input | DATA_W | Data of the evicted line |
| ins_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | Lookup request on a main-cache miss |
| lk_tag | input | TAG_W | Block address being looked up |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Looked-up line was found and removed |
| rsp_data | output | DATA_W | Returned line data, zero on miss |
| rsp_dirty | output | 1 | Returned line is modified |
| wb_valid | output | 1 | Dirty line offered to the next level |
| wb_ready | input | 1 | Next level accepts the writeback |
| wb_tag | output | TAG_W | Block address of the writeback line |
| wb_data | output | DATA_W | Data of the writeback line |

## Verification
The replacement order is kept in per-entry ranks. If a rank goes wrong, no error appears right away. It shows up only on the next insert into a full buffer: a line other than the earliest one disappears, or a writeback names the wrong tag. It can also show as a stall that follows a clean line. A stale valid bit shows up as a false hit one cycle after the next lookup of that tag. So the bench follows every cycle with a queue model and compares ins_ready and the writeback port in the same cycle, and the lookup response one cycle later. The directed cases make sure a full buffer is reached with clean, dirty and holed contents.

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int N      = 4,
  parameter int TAG_W  = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [TAG_W-1:0]  tag_q  [N];
  logic [DATA_W-1:0] data_q [N];
  logic [N-1:0]      dirty_q;
  logic [N-1:0]      vld_q;
  logic [IW-1:0]     rank_q [N];

  logic [N-1:0]  match;
  logic [IW-1:0] hit_idx, free_idx, old_idx, slot, hit_rank;
  logic          lk_hit, full, old_dirty, do_ins, wb_fire;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    hit_rank = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx  = IW'(i);
        hit_rank = rank_q[i];
      end
      if (!vld_q[i]) free_idx = IW'(i);
      if (vld_q[i] && rank_q[i] == IW'(N - 1)) old_idx = IW'(i);
    end
  end

  assign lk_hit    = lk_valid && (|match);
  assign full      = &vld_q;
  assign old_dirty = dirty_q[old_idx];
  assign ins_ready = !(full && old_dirty && !lk_hit);
  assign do_ins    = ins_valid && ins_ready;
  assign wb_valid  = ins_valid && !ins_ready;
  assign wb_fire   = wb_valid && wb_ready;
  assign wb_tag    = tag_q[old_idx];
  assign wb_data   = data_q[old_idx];
  assign slot      = lk_hit ? hit_idx : (full ? old_idx : free_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) rank_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (do_ins && slot == IW'(i)) begin
          vld_q[i]  <= 1'b1;
          rank_q[i] <= '0;
        end else if (lk_hit && hit_idx == IW'(i)) begin
          vld_q[i] <= 1'b0;
        end else if (wb_fire && old_idx == IW'(i)) begin
          vld_q[i] <= 1'b0;
        end else if (vld_q[i]) begin
          rank_q[i] <= rank_q[i] - IW'(lk_hit && rank_q[i] > hit_rank) + IW'(do_ins);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_ins) begin
      tag_q[slot]   <= ins_tag;
      data_q[slot]  <= ins_data;
      dirty_q[slot] <= ins_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_data  <= lk_hit ? data_q[hit_idx] : '0;
      rsp_dirty <= lk_hit && dirty_q[hit_idx];
    end
  end
endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_ready,
  input logic [TAG_W-1:0] ins_tag,
  input logic             lk_valid,
  input logic [TAG_W-1:0] lk_tag,
  input logic             lk_hit,
  input logic [N-1:0]     match,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             wb_valid,
  input logic             wb_ready
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  // R3
  hit_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R8
  wb_frees_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> ins_ready);

  // R10
  swap_insert_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && lk_hit) |-> (ins_ready && !wb_valid));

  // R4
  hit_removes_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> (!(lk_valid && lk_tag == $past(lk_tag)) ||
                ($past(ins_valid && ins_ready) && $past(ins_tag) == lk_tag) ||
                !lk_hit));

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

bind victim_buf victim_buf_chk #(.N(N), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_tag(ins_tag), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit),
  .match(match), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .wb_valid(wb_valid), .wb_ready(wb_ready)
);

// File: tb/sim_victim_buf.sv
module sim_victim_buf;
  localparam int NE = 4;

  logic        clk = 0, rst_n = 0;
  logic        ins_valid = 0, ins_dirty = 0, lk_valid = 0, wb_ready = 0;
  logic [31:0] ins_tag = '0, lk_tag = '0;
  logic [63:0] ins_data = '0;
  logic        ins_ready, rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [63:0] rsp_data, wb_data;
  logic [31:0] wb_tag;

  always #4 clk = ~clk;

  victim_buf u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_tag(ins_tag), .ins_data(ins_data), .ins_dirty(ins_dirty),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  typedef struct { logic [31:0] tag; logic [63:0] data; bit dirty; } line_t;
  line_t q[$];
  int    checks = 0, errors = 0;
  string cur = "";
  bit    done = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", (cur != "") ? cur : req, what, act, exp);
    end
  endtask

  function automatic int find(logic [31:0] t);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
    return -1;
  endfunction

  task automatic cyc(bit iv, logic [31:0] it, logic [63:0] id, bit idy,
                     bit lv, logic [31:0] lt, bit wr);
    int hi; bit full, fdirty, er, ewb, eh, edy; logic [63:0] ed;
    line_t n;
    ins_valid = iv; ins_tag = it; ins_data = id; ins_dirty = idy;
    lk_valid = lv; lk_tag = lt; wb_ready = wr;
    #1;
    hi = lv ? find(lt) : -1;
    full = (q.size() == NE);
    fdirty = full ? q[0].dirty : 1'b0;
    er = !(full && fdirty && hi < 0);
    ewb = iv && !er;
    chk("R8", "ins_ready", ins_ready, er);
    chk("R8", "wb_valid", wb_valid, ewb);
    if (ewb) begin
      chk("R8", "wb_tag", wb_tag, q[0].tag);
      chk("R8", "wb_data", wb_data, q[0].data);
    end
    eh = (hi >= 0);
    ed = eh ? q[hi].data : 64'd0;
    edy = eh ? q[hi].dirty : 1'b0;
    if (eh) q.delete(hi);
    if (iv && er) begin
      if (q.size() == NE) void'(q.pop_front());
      n.tag = it; n.data = id; n.dirty = idy;
      q.push_back(n);
    end else if (ewb && wr) begin
      void'(q.pop_front());
    end
    @(posedge clk); @(negedge clk);
    chk("R11", "rsp_valid", rsp_valid, lv);
    chk(eh ? "R2" : "R3", "rsp_hit", rsp_hit, eh);
    if (eh) begin
      chk("R2", "rsp_data", rsp_data, ed);
      chk("R2", "rsp_dirty", rsp_dirty, edy);
    end
  endtask

  task automatic ins(logic [31:0] t, logic [63:0] d, bit dy);
    cyc(1, t, d, dy, 0, 0, 0);
  endtask

  task automatic look(logic [31:0] t);
    cyc(0, 0, 0, 0, 1, t, 0);
  endtask

  task automatic lookx(logic [31:0] t, bit exp_hit);
    cyc(0, 0, 0, 0, 1, t, 0);
    chk("", "expected hit", rsp_hit, exp_hit);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    cur = "R1";
    chk("R1", "ins_ready", ins_ready, 1);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    lookx(32'h0000_0000, 0);

    cur = "R2";
    ins(32'h1234_5670, 64'hDEAD_BEEF_0000_0001, 1);
    lookx(32'h1234_5670, 1);
    cur = "R4";
    lookx(32'h1234_5670, 0);

    cur = "R5";
    ins(32'h8000_0001, 64'h55, 0);
    lookx(32'h0000_0001, 0);
    lookx(32'h8000_0000, 0);
    lookx(32'h8000_0001, 1);

    cur = "R6";
    for (int i = 1; i <= 5; i++) ins(32'h100 + i, 64'h1000 + i, 0);
    lookx(32'h101, 0);
    for (int i = 2; i <= 5; i++) lookx(32'h100 + i, 1);

    cur = "R7";
    for (int i = 1; i <= 4; i++) ins(32'h200 + i, 64'h2000 + i, 0);
    lookx(32'h202, 1);
    ins(32'h206, 64'h2006, 0);
    lookx(32'h201, 1);
    lookx(32'h203, 1);
    lookx(32'h204, 1);
    lookx(32'h206, 1);

    cur = "R8";
    ins(32'h301, 64'h3001, 1);
    for (int i = 2; i <= 4; i++) ins(32'h300 + i, 64'h3000 + i, 0);
    repeat (3) cyc(1, 32'h305, 64'h3005, 0, 0, 0, 0);
    chk("R8", "stall seen", wb_tag, 32'h301);
    cyc(1, 32'h305, 64'h3005, 0, 0, 0, 1);
    ins(32'h305, 64'h3005, 0);
    lookx(32'h301, 0);

    cur = "R9";
    ins(32'h306, 64'h3006, 0);
    lookx(32'h302, 0);
    for (int i = 3; i <= 6; i++) look(32'h300 + i);

    cur = "R10";
    ins(32'h401, 64'h4001, 1);
    for (int i = 2; i <= 4; i++) ins(32'h400 + i, 64'h4000 + i, 0);
    cyc(1, 32'h405, 64'h4005, 1, 1, 32'h403, 0);
    lookx(32'h401, 1);
    lookx(32'h402, 1);
    lookx(32'h404, 1);
    lookx(32'h405, 1);

    cur = "R11";
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 32'h500, 64'h1, 0, 0, 0, 0);
    look(32'h500);

    cur = "";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] t, l;
      bit iv;
      t = {1'b0, 28'(($urandom % 8) * 32'h0111_1111), 3'($urandom)};
      l = q.size() > 0 && ($urandom % 2) ? q[$urandom % q.size()].tag
                                          : {1'b0, 28'(($urandom % 8) * 32'h0111_1111), 3'($urandom)};
      iv = ($urandom % 2) && (find(t) < 0);
      cyc(iv, t, {$urandom, $urandom}, 1'($urandom), 1'($urandom), l, 1'($urandom));
    end

    done = 1;
    report();
  end
endmodule